// File: doc/BRIEF.md
# DMA Channel Control and Status Registers

This block is the software-visible register file of one channel of a scatter-gather DMA engine. A processor reaches it over a simple word-wide register bus with single-cycle write and read strobes. The stored control word drives the channel's run, soft-reset and interrupt-enable lines, and it supplies the threshold and delay settings that the interrupt coalescer uses. The block also holds the current and tail descriptor pointers. A write to the tail pointer starts the descriptor engine.

The engine and the coalescer report back into the status word through single-cycle set strobes: halted, idle, completion, delay timeout and error. A read of the control word returns the coalescer's live counters in its upper half, not the stored settings. The three interrupt flags are cleared by writing a 1 to them, and they are combined with their enables into one interrupt line. A second channel is built by placing another instance in the next address window.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset, status holds 0x0000_0001 (halted only), the stored control word is 0x0001_0000, and so ctl_thresh reads 1.
- R2: Every write to control (word offset 0x00) stores bit 1 as 1, whatever value was written to that bit.
- R3: A control write with bit 2 set loads control with 0x0001_0006 and status with 0x0000_0001, and ctl_soft_reset is high for the following cycle. Bit 2 then clears by itself one cycle later, unless a further write sets it again.
- R4: A control write with bit 0 set, bit 2 clear and the soft-reset bit not currently set clears status bits 0 (halted) and 1 (idle), and ctl_reload pulses for one cycle. While soft reset is set, that write still stores the run bit but has none of these effects.
- R5: A status write (offset 0x04) clears each of bits 14:12 written with 1, leaves each of them written with 0 unchanged, and stores the written value into every other bit.
- R6: irq is high exactly when some status bit among 14:12 is set and the control bit in the same position is also set.
- R7: A tail write (offset 0x10) stores the value, clears status bit 1, and raises start_pulse for exactly the following cycle.
- R8: A control read returns coal_timer in bits 31:24, coal_count in bits 23:16 and stored bits 15:0, with the counters sampled in the cycle of the read strobe.
- R9: The set strobes evt_halted, evt_idle, evt_ioc, evt_dly and evt_err set status bits 0, 1, 12, 13 and 14. A set takes priority over a clear by software or by the run logic in the same cycle.
- R10: Read data appears on bus_rdata one cycle after the read strobe and holds until the next read. Address bits 1:0 are ignored. Offsets other than 0x00, 0x04, 0x08 and 0x10 read as zero, and writes to them change nothing.
- R11: The current pointer (offset 0x08) takes software writes. When eng_cur_we is high, eng_cur_val is stored instead, in the same cycle as any software write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address inside the channel window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| evt_halted | input | 1 | Engine sets halted flag |
| evt_idle | input | 1 | Engine sets idle flag |
| evt_ioc | input | 1 | Coalescer sets completion flag |
| evt_dly | input | 1 | Coalescer sets delay-timeout flag |
| evt_err | input | 1 | Engine sets error flag |
| eng_cur_we | input | 1 | Engine updates current pointer |
| eng_cur_val | input | 32 | New current pointer from engine |
| coal_count | input | 8 | Live completion counter |
| coal_timer | input | 8 | Live delay timer count |
| ctl_run | output | 1 | Run control |
| ctl_soft_reset | output | 1 | Soft reset control |
| ctl_irq_en | output | 3 | Interrupt enables |
| ctl_thresh | output | 8 | Stored completion threshold |
| ctl_delay | output | 8 | Stored delay setting |
| ctl_reload | output | 1 | One-cycle counter reload request |
| start_pulse | output | 1 | One-cycle start to descriptor engine |
| cur_desc | output | 32 | Current descriptor pointer |
| tail_desc | output | 32 | Tail descriptor pointer |
| irq | output | 1 | Channel interrupt |

## Verification
The hardest case to reach from the ports is a cycle in which an event strobe and a clear aimed at the same flag land together. The clear may be a write-one-to-clear of an interrupt flag, or the run or tail logic clearing idle or halted. Directed steps line up such a collision deliberately: a completion strobe in the same cycle as a status write that clears it, and a run write issued while soft reset is still set. Random cycles then raise event strobes at a low rate during random writes to all offsets, and a bench model follows every flag.

// File: rtl/dma_regs_pkg.sv
// Package: shared register offsets, field positions and reset values
// for the DMA channel register file. Assumes a 32-bit data word.
package dma_regs_pkg;
    localparam int DW           = 32;
    localparam int WIDX_CTRL    = 0;   // byte offset 0x00
    localparam int WIDX_STAT    = 1;   // byte offset 0x04
    localparam int WIDX_CUR     = 2;   // byte offset 0x08
    localparam int WIDX_TAIL    = 4;   // byte offset 0x10
    localparam int B_RUN        = 0;
    localparam int B_TMODE      = 1;
    localparam int B_SRST       = 2;
    localparam int B_HALT       = 0;
    localparam int B_IDLE       = 1;
    localparam int IRQ_LO       = 12;
    localparam int IRQ_W        = 3;
    localparam int IRQ_HI       = IRQ_LO + IRQ_W - 1;
    localparam int B_IOC        = IRQ_LO;
    localparam int B_DLY        = IRQ_LO + 1;
    localparam int B_ERR        = IRQ_LO + 2;
    localparam int FLD_W        = 8;
    localparam int THR_LO       = 16;
    localparam int DLY_LO       = 24;
    localparam logic [DW-1:0] CTRL_RST = 32'h0001_0000;
    localparam logic [DW-1:0] STAT_RST = 32'h0000_0001;
    localparam logic [DW-1:0] CTRL_SRST_LOAD =
        CTRL_RST | (32'h1 << B_TMODE) | (32'h1 << B_SRST);

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_STAT,
        SEL_CUR,
        SEL_TAIL
    } reg_sel_e;

    typedef struct packed {
        logic err;
        logic dly;
        logic ioc;
        logic idle;
        logic halt;
    } evt_t;
endpackage

// File: rtl/dma_reg_decode.sv
// Module: address decoder. Maps a byte address to one register select.
// Assumes word-aligned access; the two low address bits are ignored.
module dma_reg_decode
    import dma_regs_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] widx;
    logic              unused_lsb;

    assign widx       = addr[ADDR_W-1:2];
    assign unused_lsb = ^addr[1:0];

    // Translate the word index into a register select.
    always_comb begin
        sel = SEL_NONE;
        if (widx == WORD_W'(WIDX_CTRL))      sel = SEL_CTRL;
        else if (widx == WORD_W'(WIDX_STAT)) sel = SEL_STAT;
        else if (widx == WORD_W'(WIDX_CUR))  sel = SEL_CUR;
        else if (widx == WORD_W'(WIDX_TAIL)) sel = SEL_TAIL;
    end
endmodule

// File: rtl/dma_ctrl_reg.sv
// Module: control register. Forces tail-pointer mode on every write,
// makes the soft-reset bit last one cycle, and flags run requests.
// Assumes wr is already qualified by the address decode.
module dma_ctrl_reg
    import dma_regs_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] ctrl_q,
    output logic          run_set,
    output logic          reload_q
);
    // A run request counts only outside soft reset.
    assign run_set = wr && wdata[B_RUN] && !wdata[B_SRST] && !ctrl_q[B_SRST];

    // Stored control word with forced mode bit and self-clearing reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RST;
        end else if (wr) begin
            if (wdata[B_SRST]) ctrl_q <= CTRL_SRST_LOAD;
            else               ctrl_q <= wdata | (DW'(1) << B_TMODE);
        end else if (ctrl_q[B_SRST]) begin
            ctrl_q[B_SRST] <= 1'b0;
        end
    end

    // One-cycle reload request to the coalescer after a run request.
    always_ff @(posedge clk) begin
        if (!rst_n) reload_q <= 1'b0;
        else        reload_q <= run_set;
    end
endmodule

// File: rtl/dma_stat_reg.sv
// Module: status register. Write-one-to-clear interrupt flags, plain
// storage for other bits, and event sets that win over any clear.
module dma_stat_reg
    import dma_regs_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic          srst_load,
    input  logic          run_clr,
    input  logic          tail_clr,
    input  evt_t          evt,
    output logic [DW-1:0] stat_q
);
    logic [DW-1:0] nxt;

    // Next status value: software write, then clears, then event sets.
    always_comb begin
        nxt = stat_q;
        if (wr) begin
            nxt                = wdata;
            nxt[IRQ_HI:IRQ_LO] = stat_q[IRQ_HI:IRQ_LO] & ~wdata[IRQ_HI:IRQ_LO];
        end
        if (srst_load) nxt = STAT_RST;
        if (run_clr) begin
            nxt[B_HALT] = 1'b0;
            nxt[B_IDLE] = 1'b0;
        end
        if (tail_clr) nxt[B_IDLE] = 1'b0;
        nxt[B_HALT] = nxt[B_HALT] | evt.halt;
        nxt[B_IDLE] = nxt[B_IDLE] | evt.idle;
        nxt[B_IOC]  = nxt[B_IOC]  | evt.ioc;
        nxt[B_DLY]  = nxt[B_DLY]  | evt.dly;
        nxt[B_ERR]  = nxt[B_ERR]  | evt.err;
    end

    // Status storage.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= STAT_RST;
        else        stat_q <= nxt;
    end
endmodule

// File: rtl/dma_ptr_reg.sv
// Module: descriptor pointer register. With ENG_UPD set, an engine
// update overrides a software write in the same cycle.
module dma_ptr_reg
    import dma_regs_pkg::*;
#(
    parameter bit ENG_UPD = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic          eng_we,
    input  logic [DW-1:0] eng_val,
    output logic [DW-1:0] ptr_q
);
    generate
        if (ENG_UPD) begin : g_eng
            // Pointer with engine update taking priority.
            always_ff @(posedge clk) begin
                if (!rst_n)      ptr_q <= '0;
                else if (eng_we) ptr_q <= eng_val;
                else if (wr)     ptr_q <= wdata;
            end
        end else begin : g_sw
            logic unused_eng;
            assign unused_eng = eng_we ^ (^eng_val);
            // Pointer written by software only.
            always_ff @(posedge clk) begin
                if (!rst_n)  ptr_q <= '0;
                else if (wr) ptr_q <= wdata;
            end
        end
    endgenerate
endmodule

// File: rtl/dma_chan_regs.sv
// Module: top of the per-channel register file. Decodes bus accesses,
// registers read data, drives engine controls and the interrupt line.
// Assumes one access of each kind per cycle at most.
module dma_chan_regs
    import dma_regs_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              evt_halted,
    input  logic              evt_idle,
    input  logic              evt_ioc,
    input  logic              evt_dly,
    input  logic              evt_err,
    input  logic              eng_cur_we,
    input  logic [31:0]       eng_cur_val,
    input  logic [7:0]        coal_count,
    input  logic [7:0]        coal_timer,
    output logic              ctl_run,
    output logic              ctl_soft_reset,
    output logic [2:0]        ctl_irq_en,
    output logic [7:0]        ctl_thresh,
    output logic [7:0]        ctl_delay,
    output logic              ctl_reload,
    output logic              start_pulse,
    output logic [31:0]       cur_desc,
    output logic [31:0]       tail_desc,
    output logic              irq
);
    localparam int NPTR = 2;

    reg_sel_e      sel;
    logic          wr_ctrl, wr_stat;
    logic [NPTR-1:0] wr_ptr;
    logic [DW-1:0] ctrl_q, stat_q;
    logic [DW-1:0] ptr_q [NPTR];
    logic          run_set;
    evt_t          evt;

    dma_reg_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    assign wr_ctrl   = bus_wr && (sel == SEL_CTRL);
    assign wr_stat   = bus_wr && (sel == SEL_STAT);
    assign wr_ptr[0] = bus_wr && (sel == SEL_CUR);
    assign wr_ptr[1] = bus_wr && (sel == SEL_TAIL);
    assign evt       = '{err: evt_err, dly: evt_dly, ioc: evt_ioc,
                         idle: evt_idle, halt: evt_halted};

    dma_ctrl_reg u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (wr_ctrl),
        .wdata    (bus_wdata),
        .ctrl_q   (ctrl_q),
        .run_set  (run_set),
        .reload_q (ctl_reload)
    );

    dma_stat_reg u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (wr_stat),
        .wdata     (bus_wdata),
        .srst_load (wr_ctrl && bus_wdata[B_SRST]),
        .run_clr   (run_set),
        .tail_clr  (wr_ptr[1]),
        .evt       (evt),
        .stat_q    (stat_q)
    );

    // Pointer 0 is the current descriptor, pointer 1 the tail.
    generate
        for (genvar i = 0; i < NPTR; i++) begin : g_ptr
            dma_ptr_reg #(.ENG_UPD(i == 0)) u_ptr (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr      (wr_ptr[i]),
                .wdata   (bus_wdata),
                .eng_we  ((i == 0) ? eng_cur_we : 1'b0),
                .eng_val (eng_cur_val),
                .ptr_q   (ptr_q[i])
            );
        end
    endgenerate

    // One-cycle start request after each tail write.
    always_ff @(posedge clk) begin
        if (!rst_n) start_pulse <= 1'b0;
        else        start_pulse <= wr_ptr[1];
    end

    // Registered read-back; control shows live coalescer counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            unique case (sel)
                SEL_CTRL: bus_rdata <= {coal_timer, coal_count, ctrl_q[THR_LO-1:0]};
                SEL_STAT: bus_rdata <= stat_q;
                SEL_CUR:  bus_rdata <= ptr_q[0];
                SEL_TAIL: bus_rdata <= ptr_q[1];
                default:  bus_rdata <= '0;
            endcase
        end
    end

    assign ctl_run        = ctrl_q[B_RUN];
    assign ctl_soft_reset = ctrl_q[B_SRST];
    assign ctl_irq_en     = ctrl_q[IRQ_HI:IRQ_LO];
    assign ctl_thresh     = ctrl_q[THR_LO +: FLD_W];
    assign ctl_delay      = ctrl_q[DLY_LO +: FLD_W];
    assign cur_desc       = ptr_q[0];
    assign tail_desc      = ptr_q[1];
    assign irq            = |(stat_q[IRQ_HI:IRQ_LO] & ctrl_q[IRQ_HI:IRQ_LO]);
endmodule

// File: rtl/dma_chan_regs_chk.sv
// Module: assertion checker bound to the register file top.
module dma_chan_regs_chk #(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-3:0] widx,
    input logic              wd_srst,
    input logic [2:0]        wd_irq,
    input logic              evt_ioc,
    input logic              evt_dly,
    input logic              evt_err,
    input logic              start_pulse,
    input logic              ctl_soft_reset,
    input logic [7:0]        ctl_thresh,
    input logic              irq,
    input logic [31:0]       stat_q
);
    localparam int WW = ADDR_W - 2;

    assert_reset_vals_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (stat_q == 32'h1 && ctl_thresh == 8'd1));

    assert_srst_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_soft_reset && !(bus_wr && widx == WW'(0) && wd_srst)) |=> !ctl_soft_reset);

    assert_w1c_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && widx == WW'(1) && wd_irq == 3'b111 && !evt_ioc && !evt_dly && !evt_err)
        |=> !irq);

    assert_tail_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && widx == WW'(4)) |=> start_pulse);

    assert_start_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> $past(bus_wr && widx == WW'(4)));

    assert_event_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        evt_ioc |=> stat_q[12]);
endmodule

bind dma_chan_regs dma_chan_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .bus_wr         (bus_wr),
    .widx           (bus_addr[ADDR_W-1:2]),
    .wd_srst        (bus_wdata[2]),
    .wd_irq         (bus_wdata[14:12]),
    .evt_ioc        (evt_ioc),
    .evt_dly        (evt_dly),
    .evt_err        (evt_err),
    .start_pulse    (start_pulse),
    .ctl_soft_reset (ctl_soft_reset),
    .ctl_thresh     (ctl_thresh),
    .irq            (irq),
    .stat_q         (stat_q)
);

// File: tb/dma_chan_regs_tb.sv
// Bench: directed corner cases plus seeded random cycles, checked
// against a cycle model built from the requirements.
module dma_chan_regs_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_wr, bus_rd;
    logic [5:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic        evt_halted, evt_idle, evt_ioc, evt_dly, evt_err;
    logic        eng_cur_we;
    logic [31:0] eng_cur_val;
    logic [7:0]  coal_count, coal_timer;
    logic        ctl_run, ctl_soft_reset, ctl_reload, start_pulse, irq;
    logic [2:0]  ctl_irq_en;
    logic [7:0]  ctl_thresh, ctl_delay;
    logic [31:0] cur_desc, tail_desc;

    int n_checks = 0;
    int n_errors = 0;

    logic [31:0] m_ctrl, m_stat, m_cur, m_tail, m_rdata;
    logic        m_start, m_reload;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_chan_regs u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_halted(evt_halted), .evt_idle(evt_idle), .evt_ioc(evt_ioc),
        .evt_dly(evt_dly), .evt_err(evt_err), .eng_cur_we(eng_cur_we),
        .eng_cur_val(eng_cur_val), .coal_count(coal_count), .coal_timer(coal_timer),
        .ctl_run(ctl_run), .ctl_soft_reset(ctl_soft_reset), .ctl_irq_en(ctl_irq_en),
        .ctl_thresh(ctl_thresh), .ctl_delay(ctl_delay), .ctl_reload(ctl_reload),
        .start_pulse(start_pulse), .cur_desc(cur_desc), .tail_desc(tail_desc),
        .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [5:0] a, input logic [7:0] c,
                                               input logic [7:0] t);
        case (a[5:2])
            4'd0:    return {t, c, m_ctrl[15:0]};
            4'd1:    return m_stat;
            4'd2:    return m_cur;
            4'd4:    return m_tail;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string read_tag(input logic [5:0] a);
        case (a[5:2])
            4'd0:    return "R8 control read";
            4'd1:    return "R5 status read";
            4'd2:    return "R11 current pointer read";
            4'd4:    return "R7 tail read";
            default: return "R10 unmapped read";
        endcase
    endfunction

    // One bus cycle: drive, advance the model, check after the edge.
    task automatic cyc(input logic wr, input logic rd, input logic [5:0] a,
                       input logic [31:0] wd, input logic [4:0] ev,
                       input logic cwe, input logic [31:0] cv,
                       input logic [7:0] c, input logic [7:0] t);
        logic [31:0] nc, ns, ncur, ntail;
        logic        runset;
        logic [3:0]  w;
        string       rtag;
        w = a[5:2];
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd;
        {evt_err, evt_dly, evt_ioc, evt_idle, evt_halted} = ev;
        eng_cur_we = cwe; eng_cur_val = cv; coal_count = c; coal_timer = t;
        nc = m_ctrl;
        if (wr && w == 0) nc = wd[2] ? 32'h0001_0006 : (wd | 32'h2);
        else if (m_ctrl[2]) nc[2] = 1'b0;
        runset = wr && w == 0 && wd[0] && !wd[2] && !m_ctrl[2];
        ns = m_stat;
        if (wr && w == 1) begin
            ns = wd;
            ns[14:12] = m_stat[14:12] & ~wd[14:12];
        end
        if (wr && w == 0 && wd[2]) ns = 32'h1;
        if (runset) ns[1:0] = 2'b00;
        if (wr && w == 4) ns[1] = 1'b0;
        ns[0] |= ev[0]; ns[1] |= ev[1]; ns[12] |= ev[2]; ns[13] |= ev[3]; ns[14] |= ev[4];
        ncur  = cwe ? cv : ((wr && w == 2) ? wd : m_cur);
        ntail = (wr && w == 4) ? wd : m_tail;
        rtag = read_tag(a);
        if (rd) m_rdata = model_read(a, c, t);
        @(posedge clk);
        m_ctrl = nc; m_stat = ns; m_cur = ncur; m_tail = ntail;
        m_start = wr && w == 4; m_reload = runset;
        @(negedge clk);
        if (rd) chk(rtag, bus_rdata, m_rdata);
        chk("R6 irq", {31'b0, irq}, {31'b0, |(m_stat[14:12] & m_ctrl[14:12])});
        chk("R7 start_pulse", {31'b0, start_pulse}, {31'b0, m_start});
        chk("R4 ctl_reload", {31'b0, ctl_reload}, {31'b0, m_reload});
        chk("R3 ctl_soft_reset", {31'b0, ctl_soft_reset}, {31'b0, m_ctrl[2]});
    endtask

    task automatic idle_cyc();
        cyc(1'b0, 1'b0, 6'h0, 32'h0, 5'h0, 1'b0, 32'h0, 8'h0, 8'h0);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 1'b0;
        bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
        {evt_err, evt_dly, evt_ioc, evt_idle, evt_halted} = 5'h0;
        eng_cur_we = 0; eng_cur_val = 0; coal_count = 0; coal_timer = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_ctrl = 32'h0001_0000; m_stat = 32'h1; m_cur = 0; m_tail = 0;
        m_rdata = 0; m_start = 0; m_reload = 0;

        // R1: reset values
        chk("R1 ctl_thresh", {24'b0, ctl_thresh}, 32'd1);
        cyc(0, 1, 6'h04, 0, 0, 0, 0, 0, 0);
        chk("R1 status after reset", bus_rdata, 32'h1);
        cyc(0, 1, 6'h00, 0, 0, 0, 0, 8'h05, 8'h09);
        chk("R1 control after reset", bus_rdata, 32'h0905_0000);

        // R2, R4: run write with enables, mode bit forced
        cyc(1, 0, 6'h00, 32'h0000_7001, 0, 0, 0, 0, 0);
        cyc(0, 1, 6'h00, 0, 0, 0, 0, 8'h05, 8'h09);
        chk("R2 tail mode bit forced", bus_rdata, 32'h0905_7003);
        chk("R4 ctl_run", {31'b0, ctl_run}, 32'd1);

        // R9, R6: event raises flag and irq
        cyc(0, 0, 6'h00, 0, 5'b00100, 0, 0, 0, 0);
        chk("R9 completion flag raises irq", {31'b0, irq}, 32'd1);

        // R9: event wins over same-cycle write-one-to-clear
        cyc(1, 0, 6'h04, 32'h0000_1000, 5'b00100, 0, 0, 0, 0);
        cyc(0, 1, 6'h04, 0, 0, 0, 0, 0, 0);
        chk("R9 set beats clear", bus_rdata, 32'h0000_1000);
        cyc(1, 0, 6'h04, 32'h0000_7000, 0, 0, 0, 0, 0);
        cyc(0, 1, 6'h04, 0, 0, 0, 0, 0, 0);
        chk("R5 flags cleared", bus_rdata, 32'h0);

        // R3, R4: soft reset, then run write ignored while in reset
        cyc(1, 0, 6'h00, 32'h0000_0005, 0, 0, 0, 0, 0);
        cyc(1, 0, 6'h00, 32'h0000_0001, 0, 0, 0, 0, 0);
        cyc(0, 1, 6'h04, 0, 0, 0, 0, 0, 0);
        chk("R4 run ignored in soft reset", bus_rdata, 32'h1);
        chk("R3 reset bit cleared", {31'b0, ctl_soft_reset}, 32'd0);

        // R7: run then tail write
        cyc(1, 0, 6'h00, 32'h0000_0001, 0, 0, 0, 0, 0);
        cyc(1, 0, 6'h10, 32'h0000_0100, 5'b00010, 0, 0, 0, 0);
        cyc(1, 0, 6'h10, 32'h0000_0140, 0, 0, 0, 0, 0);
        cyc(0, 1, 6'h11, 0, 0, 0, 0, 0, 0);
        chk("R7 tail stored", tail_desc, 32'h0000_0140);

        // R11: engine update beats software write
        cyc(1, 0, 6'h08, 32'h0000_0200, 0, 1, 32'h0000_0300, 0, 0);
        cyc(0, 1, 6'h08, 0, 0, 0, 0, 0, 0);
        chk("R11 engine wins", bus_rdata, 32'h0000_0300);

        // R10: unmapped offsets
        cyc(1, 0, 6'h0C, 32'hDEAD_BEEF, 0, 0, 0, 0, 0);
        cyc(1, 0, 6'h20, 32'hCAFE_F00D, 0, 0, 0, 0, 0);
        cyc(0, 1, 6'h0C, 0, 0, 0, 0, 0, 0);
        chk("R10 unmapped 0x0C", bus_rdata, 32'h0);
        cyc(0, 1, 6'h34, 0, 0, 0, 0, 0, 0);
        idle_cyc();
        chk("R10 read data held", bus_rdata, 32'h0);
        cyc(0, 1, 6'h06, 0, 0, 0, 0, 0, 0);

        // Seeded random cycles
        for (int i = 0; i < 3000; i++) begin
            logic [5:0]  a;
            logic [31:0] wd;
            logic [4:0]  ev;
            case ($urandom % 6)
                0: a = 6'h00;
                1: a = 6'h04;
                2: a = 6'h08;
                3: a = 6'h10;
                default: a = 6'($urandom);
            endcase
            wd = $urandom;
            if (a[5:2] == 0 && ($urandom % 8) != 0) wd[2] = 1'b0;
            ev = 5'h0;
            for (int k = 0; k < 5; k++) ev[k] = (($urandom % 10) == 0);
            cyc(($urandom % 2) == 0, ($urandom % 2) == 0, a, wd, ev,
                ($urandom % 12) == 0, $urandom, 8'($urandom), 8'($urandom));
        end

        finish_run();
    end
endmodule